// File: doc/BRIEF.md
# Single-Pass Carry Absorber with Leftover-Carry Detect

This block takes a wide integer held in carry-save form: a row of fixed-width limbs plus one carry bit per limb, where each carry bit belongs to the limb above its own. It runs one absorption step in which every limb adds, at the same time, the carry bit of the limb just below it. The block does not ripple the result any further. It then reduces the carry bits produced by that step through a balanced OR tree, ceil(log2) levels deep, and raises a pending flag if any of them would still have to move up into a higher limb.

A datapath controller uses the block after a long chain of multiply-accumulate steps. When the pending flag is low, the absorbed limbs are the exact value. When it is high, the controller starts a slower exact recomputation. Fully rippling a carry through s limbs takes s-1 dependent add steps. One absorption step is enough for almost all operand values, and the one-level check keeps this common case short.

A carry that leaves the top limb is not fed back into limb 0. It appears on a separate overflow output.

Top module: `carry_absorb_check`

## Requirements
- R1: While reset is held and after it is released, `outVld`, `carryPending` and `topOverflow` are 0 and `outLimbs` is all zeros, until the first valid input arrives.
- R2: For every limb j >= 1, output limb j equals (input limb j + inCarry[j-1]) mod 2^LIMB_W. Limb j occupies bits [j*LIMB_W +: LIMB_W] and carry bit j is inCarry[j].
- R3: Output limb 0 equals input limb 0, because limb 0 receives no carry. The top carry never wraps around into limb 0.
- R4: `carryPending` is 1 exactly when some limb j with j < NUM_LIMBS-1 is all ones and receives a carry, which means the absorption step produced a new carry that still has to go up.
- R5: `topOverflow` is 1 exactly when inCarry[NUM_LIMBS-1] is 1 or the top limb is all ones and receives a carry.
- R6: Results and `outVld` appear one clock after a cycle in which `inVld` is high. After a cycle in which `inVld` is low, `outVld` is 0 and all result outputs keep their previous values.
- R7: An all-ones limb that receives a carry comes out as zero and raises `carryPending`. This case is a ripple that one absorption step cannot complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Input operand valid |
| inLimbs | input | NUM_LIMBS*LIMB_W | Carry-save limbs, limb 0 in the low bits |
| inCarry | input | NUM_LIMBS | Carry bit out of each limb |
| outVld | output | 1 | Result valid, one cycle after inVld |
| outLimbs | output | NUM_LIMBS*LIMB_W | Limbs after one absorption step |
| carryPending | output | 1 | A new carry is still inside the value |
| topOverflow | output | 1 | Carry leaving the top limb |

## Verification
The properties assume that `inVld` and the operand buses are stable around the capturing edge. They also assume that every carry bit is a single bit belonging to its own limb, with no multi-bit carries. The stimulus changes inputs only on the falling clock edge. It sweeps every combination of limb and carry bits in a reduced configuration of four two-bit limbs, so every ripple and overflow pattern lies inside that assumed input space. Idle cycles placed between groups of vectors exercise the hold behaviour.

// File: rtl/carry_absorb_pkg.sv
package carry_absorb_pkg;
  typedef struct packed {
    logic capture;
    logic resVld;
  } absorbStrobes_t;
endpackage

// File: rtl/or_reduce_tree.sv
module or_reduce_tree #(
  parameter int N = 31
) (
  input  logic [N-1:0] bitsIn,
  output logic         anySet
);
  localparam int LVLS = (N > 1) ? $clog2(N) : 0;
  localparam int PAD  = 1 << LVLS;

  logic [LVLS:0][PAD-1:0] lvl;

  generate
    if (PAD > N) begin : g_pad
      assign lvl[0] = {{(PAD-N){1'b0}}, bitsIn};
    end else begin : g_nopad
      assign lvl[0] = bitsIn;
    end
    for (genvar k = 0; k < LVLS; k++) begin : g_level
      localparam int W = PAD >> (k + 1);
      for (genvar i = 0; i < W; i++) begin : g_node
        assign lvl[k+1][i] = lvl[k][2*i] | lvl[k][2*i+1];
      end
      assign lvl[k+1][PAD-1:W] = '0;
    end
  endgenerate

  assign anySet = lvl[LVLS][0];
endmodule

// File: rtl/absorb_ctrl.sv
module absorb_ctrl
  import carry_absorb_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inVld,
  output absorbStrobes_t strobes
);
  logic vldQ;

  always_ff @(posedge clk) begin
    if (!rstN) vldQ <= 1'b0;
    else       vldQ <= inVld;
  end

  always_comb begin
    strobes.capture = inVld;
    strobes.resVld  = vldQ;
  end
endmodule

// File: rtl/absorb_datapath.sv
module absorb_datapath
  import carry_absorb_pkg::*;
#(
  parameter int NUM_LIMBS = 32,
  parameter int LIMB_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  absorbStrobes_t                strobes,
  input  logic [NUM_LIMBS*LIMB_W-1:0]   inLimbs,
  input  logic [NUM_LIMBS-1:0]          inCarry,
  output logic [NUM_LIMBS*LIMB_W-1:0]   resLimbs,
  output logic                          pending,
  output logic                          overflow
);
  localparam int TOTAL_W = NUM_LIMBS * LIMB_W;
  localparam int TOP     = NUM_LIMBS - 1;

  logic [TOTAL_W-1:0]   heldLimbs;
  logic [NUM_LIMBS-1:0] heldCarry;
  logic [NUM_LIMBS-1:0] newCarry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldLimbs <= '0;
      heldCarry <= '0;
    end else if (strobes.capture) begin
      heldLimbs <= inLimbs;
      heldCarry <= inCarry;
    end
  end

  generate
    for (genvar j = 0; j < NUM_LIMBS; j++) begin : g_limb
      logic cIn;
      if (j == 0) begin : g_base
        assign cIn = 1'b0;
      end else begin : g_upper
        assign cIn = heldCarry[j-1];
      end
      assign {newCarry[j], resLimbs[j*LIMB_W +: LIMB_W]} =
        {1'b0, heldLimbs[j*LIMB_W +: LIMB_W]} + {{LIMB_W{1'b0}}, cIn};
    end
  endgenerate

  or_reduce_tree #(.N(NUM_LIMBS-1)) u_tree (
    .bitsIn (newCarry[TOP-1:0]),
    .anySet (pending)
  );

  assign overflow = heldCarry[TOP] | newCarry[TOP];
endmodule

// File: rtl/carry_absorb_check.sv
module carry_absorb_check
  import carry_absorb_pkg::*;
#(
  parameter int NUM_LIMBS = 32,
  parameter int LIMB_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inVld,
  output logic                        outVld,
  input  logic [NUM_LIMBS*LIMB_W-1:0] inLimbs,
  input  logic [NUM_LIMBS-1:0]        inCarry,
  output logic [NUM_LIMBS*LIMB_W-1:0] outLimbs,
  output logic                        carryPending,
  output logic                        topOverflow
);
  absorbStrobes_t strobes;

  absorb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inVld   (inVld),
    .strobes (strobes)
  );

  absorb_datapath #(.NUM_LIMBS(NUM_LIMBS), .LIMB_W(LIMB_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inLimbs  (inLimbs),
    .inCarry  (inCarry),
    .resLimbs (outLimbs),
    .pending  (carryPending),
    .overflow (topOverflow)
  );

  assign outVld = strobes.resVld;
endmodule

// File: rtl/carry_absorb_check_sva.sv
module carry_absorb_check_sva #(
  parameter int NUM_LIMBS = 32,
  parameter int LIMB_W    = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        inVld,
  input logic                        outVld,
  input logic [NUM_LIMBS*LIMB_W-1:0] inLimbs,
  input logic [NUM_LIMBS-1:0]        inCarry,
  input logic [NUM_LIMBS*LIMB_W-1:0] outLimbs,
  input logic                        carryPending,
  input logic                        topOverflow
);
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outVld);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> (!outVld && $stable(outLimbs) && $stable(carryPending) && $stable(topOverflow)));

  a_r3_limb0_passthru: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outLimbs[LIMB_W-1:0] == $past(inLimbs[LIMB_W-1:0]));

  a_r5_top_carry: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inCarry[NUM_LIMBS-1]) |=> topOverflow);

  a_r7_ripple_flag: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inCarry[0] && (inLimbs[LIMB_W +: LIMB_W] == {LIMB_W{1'b1}})) |=> carryPending);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!outVld && !carryPending && !topOverflow));
endmodule

bind carry_absorb_check carry_absorb_check_sva #(.NUM_LIMBS(NUM_LIMBS), .LIMB_W(LIMB_W)) u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .inVld        (inVld),
  .outVld       (outVld),
  .inLimbs      (inLimbs),
  .inCarry      (inCarry),
  .outLimbs     (outLimbs),
  .carryPending (carryPending),
  .topOverflow  (topOverflow)
);

// File: tb/tb_carry_absorb_check.sv
module tb_carry_absorb_check;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int TW = NL * LW;
  localparam int LMAX = (1 << LW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inVld = 1'b0;
  logic [TW-1:0] inLimbs = '0;
  logic [NL-1:0] inCarry = '0;
  logic          outVld;
  logic [TW-1:0] outLimbs;
  logic          carryPending;
  logic          topOverflow;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  carry_absorb_check #(.NUM_LIMBS(NL), .LIMB_W(LW)) dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .outVld(outVld),
    .inLimbs(inLimbs), .inCarry(inCarry), .outLimbs(outLimbs),
    .carryPending(carryPending), .topOverflow(topOverflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [TW-1:0] l, input logic [NL-1:0] c,
                                output logic [TW-1:0] r, output bit pend, output bit ovf);
    pend = 0; ovf = c[NL-1];
    for (int j = 0; j < NL; j++) begin
      int s;
      s = int'(l[j*LW +: LW]) + ((j == 0) ? 0 : int'(c[j-1]));
      r[j*LW +: LW] = s[LW-1:0];
      if (s > LMAX) begin
        if (j == NL-1) ovf = 1;
        else pend = 1;
      end
    end
  endfunction

  task automatic apply(input logic [TW-1:0] l, input logic [NL-1:0] c);
    logic [TW-1:0] er;
    bit ep, eo;
    @(negedge clk);
    inVld = 1'b1; inLimbs = l; inCarry = c;
    @(negedge clk);
    model(l, c, er, ep, eo);
    chk("R6 outVld", int'(outVld), 1);
    chk("R2 limbs", int'(outLimbs), int'(er));
    chk("R3 limb0", int'(outLimbs[LW-1:0]), int'(l[LW-1:0]));
    chk("R4 pending", int'(carryPending), int'(ep));
    chk("R5 overflow", int'(topOverflow), int'(eo));
    inVld = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] lastOut;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outVld", int'(outVld), 0);
    chk("R1 pending", int'(carryPending), 0);
    chk("R1 overflow", int'(topOverflow), 0);
    chk("R1 limbs", int'(outLimbs), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'({outVld, carryPending, topOverflow}), 0);

    // R7 directed ripple: limb1 all ones with carry from limb0
    apply({2'b00, 2'b00, 2'b11, 2'b01}, 4'b0001);
    chk("R7 zeroed limb", int'(outLimbs[LW +: LW]), 0);
    chk("R7 pending", int'(carryPending), 1);
    // R7 full ones chain: every limb all ones, every carry set
    apply({TW{1'b1}}, {NL{1'b1}});
    chk("R7 chain pending", int'(carryPending), 1);
    chk("R5 chain overflow", int'(topOverflow), 1);
    chk("R3 no wrap", int'(outLimbs[LW-1:0]), LMAX);

    // Exhaustive sweep (R2 R3 R4 R5), with idle hold checks (R6)
    for (int v = 0; v < (1 << (TW + NL)); v++) begin
      apply(TW'(v), NL'(v >> TW));
      if ((v % 64) == 63) begin
        lastOut = outLimbs;
        @(negedge clk);
        chk("R6 idle outVld", int'(outVld), 0);
        chk("R6 hold limbs", int'(outLimbs), int'(lastOut));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule